// File: doc/BRIEF.md
# Reload Timer with PWM and Tone Output

An 8-bit up-counting timer that advances on a prescaled tick of the system clock or on rising edges of an external event pin. The counter finishes a period when its low bits, at a selected width of 8, 6, 5 or 4 bits, are all ones on an advancing tick. In plain timer mode it then either reloads from a stored reload value or wraps to zero, and it raises a sticky overflow request.

The same stored value acts as the PWM duty. One output pin carries either a PWM wave or a square wave that inverts on every overflow. In PWM mode the counter runs freely over the selected width, so the period is 256, 64, 32 or 16 ticks. A duty written while the timer runs is held in a shadow register and takes effect only at the next period boundary, so the running pulse is never cut short or stretched.

When the event pin clocks the counter, that pin's own edge request is held at zero.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset the count is 0, both request outputs are 0 and the output pin is 0.
- R2: While enabled with the internal source, the count rises by one every 2^(7-rate_sel) clocks. With enable low the count holds.
- R3: A count write loads cnt_wdata on the next edge and takes priority over counting.
- R4: An overflow is a tick with the low W bits of the count all ones. With reload_en=1 and pwm_en=0 the count then takes the reload value masked to W bits. Otherwise the count takes the incremented value masked to W bits, which gives 00h.
- R5: ovf_irq is set on every overflow and cleared by irq_clr. When both happen in the same cycle, the set wins.
- R6: The tone signal starts at 0 and inverts on each overflow. It drives out_pin when tog_en=1 and pwm_en=0.
- R7: With pwm_en=1, out_pin is high while the low W bits of the count are less than the active duty. The active duty is the stored value masked to W bits, so one period holds exactly that many high cycles.
- R8: width_sel encodes the width W: 0 gives 8 bits, 1 gives 6, 2 gives 5 and 3 gives 4.
- R9: While enabled, a new stored value becomes the active duty only at an overflow. While disabled, the active duty follows the stored value every cycle.
- R10: With ext_sel=1, each synchronized rising edge of ext_pin advances the count by one, and the prescaler has no effect.
- R11: With ext_sel=0, a synchronized rising edge of ext_pin sets pin_irq, and pin_irq_clr clears it. With ext_sel=1, pin_irq is 0 from the next cycle on.
- R12: pwm_en takes priority over tog_en on out_pin. With both low, out_pin is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Counter run enable |
| ext_sel | input | 1 | 1: count edges of ext_pin. 0: count prescaled ticks |
| reload_en | input | 1 | Reload on overflow in timer mode |
| tog_en | input | 1 | Route the tone signal to out_pin |
| pwm_en | input | 1 | Route PWM to out_pin and let the counter run freely |
| rate_sel | input | 3 | Prescaler select. Tick every 2^(7-rate_sel) clocks |
| width_sel | input | 2 | Period width select (8/6/5/4 bits) |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write data |
| rld_wr | input | 1 | Reload/duty write strobe |
| rld_wdata | input | 8 | Reload/duty write data |
| irq_clr | input | 1 | Clear the overflow request |
| ext_pin | input | 1 | External event / edge-request pin |
| pin_irq_clr | input | 1 | Clear the pin edge request |
| count | output | 8 | Current count |
| ovf_irq | output | 1 | Overflow request |
| pin_irq | output | 1 | Pin edge request |
| out_pin | output | 1 | PWM or tone output |

## Verification
The hardest case to reach from the ports is a duty write that lands in the middle of a running PWM period. The new value must stay invisible until the counter wraps.

The stimulus runs an 8-bit period at duty 40h and waits on the count port until it reads 10h. It then writes C0h and compares every output cycle against the old threshold up to the wrap, and against the new threshold for the full period after it.

A sweep over every duty at every width counts the high cycles in one period. A counting window of exactly one period needs no alignment to the period boundary.

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer #(
  parameter int CW    = 8,
  parameter int PRE_W = 7,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          ext_sel,
  input  logic          reload_en,
  input  logic          tog_en,
  input  logic          pwm_en,
  input  logic [2:0]    rate_sel,
  input  logic [1:0]    width_sel,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          rld_wr,
  input  logic [CW-1:0] rld_wdata,
  input  logic          irq_clr,
  input  logic          ext_pin,
  input  logic          pin_irq_clr,
  output logic [CW-1:0] count,
  output logic          ovf_irq,
  output logic          pin_irq,
  output logic          out_pin
);
  localparam logic [CW-1:0]    ALL1 = {CW{1'b1}};
  localparam logic [PRE_W-1:0] PALL = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre;
  logic [SYNC:0]    psync;
  logic [CW-1:0]    shadow, duty, wmask, low;
  logic             tog, tick, ovf, pin_rise, int_tick;

  wire [PRE_W-1:0] pre_mask = PALL >> rate_sel;
  assign int_tick = (pre & pre_mask) == pre_mask;
  assign pin_rise = psync[SYNC-1] & ~psync[SYNC];
  assign tick     = enable & (ext_sel ? pin_rise : int_tick);

  always_comb begin
    case (width_sel)
      2'd0:    wmask = ALL1;
      2'd1:    wmask = ALL1 >> 2;
      2'd2:    wmask = ALL1 >> 3;
      default: wmask = ALL1 >> 4;
    endcase
  end

  assign low = count & wmask;
  assign ovf = tick & (low == wmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      psync <= '0;
    end else begin
      pre   <= pre + 1'b1;
      psync <= {psync[SYNC-1:0], ext_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_wr) begin
      count <= cnt_wdata;
    end else if (ovf) begin
      count <= (reload_en & ~pwm_en) ? (shadow & wmask) : ((count + 1'b1) & wmask);
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      duty   <= '0;
    end else begin
      if (rld_wr) shadow <= rld_wdata;
      if (!enable || ovf) duty <= shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog     <= 1'b0;
      ovf_irq <= 1'b0;
      pin_irq <= 1'b0;
    end else begin
      if (ovf) tog <= ~tog;
      if (ovf) ovf_irq <= 1'b1;
      else if (irq_clr) ovf_irq <= 1'b0;
      if (ext_sel) pin_irq <= 1'b0;
      else if (pin_rise) pin_irq <= 1'b1;
      else if (pin_irq_clr) pin_irq <= 1'b0;
    end
  end

  wire pwm = low < (duty & wmask);
  assign out_pin = pwm_en ? pwm : (tog_en & tog);
endmodule

// File: rtl/reload_pwm_timer_props.sv
module reload_pwm_timer_props #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          ext_sel,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt_wdata,
  input logic          irq_clr,
  input logic          pwm_en,
  input logic          tog_en,
  input logic          out_pin,
  input logic          ovf_irq,
  input logic          pin_irq,
  input logic [CW-1:0] count
);
  assert_pin_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |=> !pin_irq);
  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq && !irq_clr |=> ovf_irq);
  assert_irq_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !$rose(ovf_irq));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !cnt_wr |=> $stable(count));
  assert_count_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(cnt_wdata));
  assert_out_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en && !tog_en |-> !out_pin);
endmodule

bind reload_pwm_timer reload_pwm_timer_props #(.CW(CW)) u_props (.*);

// File: tb/test_reload_pwm_timer.sv
module test_reload_pwm_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, ext_sel = 0, reload_en = 0, tog_en = 0, pwm_en = 0;
  logic [2:0] rate_sel = 3'd7;
  logic [1:0] width_sel = 2'd0;
  logic cnt_wr = 0, rld_wr = 0, irq_clr = 0, ext_pin = 0, pin_irq_clr = 0;
  logic [7:0] cnt_wdata = 0, rld_wdata = 0;
  logic [7:0] count;
  logic ovf_irq, pin_irq, out_pin;

  int checks = 0, fails = 0;
  bit done = 0;

  reload_pwm_timer i_reload_pwm_timer (.*);

  always #4 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    int w, n, hi, errs, c0, t0;
    repeat (3) step();
    rst_n = 1;
    step();
    check(count == 0, "R1 count", count, 0);
    check(!ovf_irq && !pin_irq, "R1 irqs", ovf_irq + pin_irq, 0);
    check(!out_pin, "R1 out", out_pin, 0);

    // R7 R8 duty sweep over every width (W = 8,6,5,4 for width_sel 0..3)
    for (int s = 0; s < 4; s++) begin
      w = (s == 0) ? 8 : (s == 1) ? 6 : (s == 2) ? 5 : 4;
      n = 1 << w;
      for (int d = 0; d < n; d++) begin
        enable = 0; pwm_en = 1; width_sel = s[1:0];
        rld_wr = 1; rld_wdata = d[7:0]; step();
        rld_wr = 0; cnt_wr = 1; cnt_wdata = 0; step();
        cnt_wr = 0; enable = 1;
        hi = 0;
        for (int i = 0; i < n; i++) begin step(); if (out_pin) hi++; end
        check(hi == d, "R7 R8 highs per period", hi, d);
      end
    end

    // R7 duty masked to width: 25h at 4 bits -> 5
    enable = 0; width_sel = 2'd3; rld_wr = 1; rld_wdata = 8'h25; step();
    rld_wr = 0; cnt_wr = 1; cnt_wdata = 0; step();
    cnt_wr = 0; enable = 1; hi = 0;
    for (int i = 0; i < 16; i++) begin step(); if (out_pin) hi++; end
    check(hi == 5, "R7 masked duty", hi, 5);

    // R9 duty write mid-period
    enable = 0; width_sel = 0; rld_wr = 1; rld_wdata = 8'h40; step();
    rld_wr = 0; cnt_wr = 1; cnt_wdata = 0; step();
    cnt_wr = 0; enable = 1;
    while (count != 8'h10) step();
    rld_wr = 1; rld_wdata = 8'hC0; step();
    rld_wr = 0; errs = 0;
    while (count != 0) begin
      if (out_pin != (count < 8'h40)) errs++;
      step();
    end
    check(errs == 0, "R9 old duty until wrap", errs, 0);
    errs = 0;
    for (int i = 0; i < 256; i++) begin
      if (out_pin != (count < 8'hC0)) errs++;
      step();
    end
    check(errs == 0, "R9 new duty after wrap", errs, 0);

    // R4 R5 R6 timer reload
    enable = 0; pwm_en = 0; tog_en = 1; reload_en = 1;
    rld_wr = 1; rld_wdata = 8'hF0; irq_clr = 1; step();
    rld_wr = 0; irq_clr = 0; cnt_wr = 1; cnt_wdata = 8'hFD; step();
    cnt_wr = 0; enable = 1; t0 = out_pin;
    check(count == 8'hFD, "R3 load", count, 8'hFD);
    step(); step();
    check(count == 8'hFF && !ovf_irq, "R5 no irq before ovf", {ovf_irq, count}, 8'hFF);
    step();
    check(count == 8'hF0, "R4 reload", count, 8'hF0);
    check(ovf_irq, "R5 set on ovf", ovf_irq, 1);
    check(out_pin == !t0, "R6 tone flips", out_pin, !t0);
    irq_clr = 1; step(); irq_clr = 0;
    check(!ovf_irq, "R5 clear", ovf_irq, 0);
    while (count != 8'hFF) step();
    irq_clr = 1; step(); irq_clr = 0;
    check(ovf_irq && count == 8'hF0, "R5 set wins over clear", ovf_irq, 1);

    // R4 wrap without reload, 8 and 4 bits
    reload_en = 0; irq_clr = 1; cnt_wr = 1; cnt_wdata = 8'hFE; step();
    irq_clr = 0; cnt_wr = 0; step(); step();
    check(count == 0, "R4 wrap 8-bit", count, 0);
    width_sel = 2'd3; irq_clr = 1; cnt_wr = 1; cnt_wdata = 8'h3E; step();
    irq_clr = 0; cnt_wr = 0; step();
    check(count == 8'h3F && !ovf_irq, "R4 R8 4-bit before ovf", count, 8'h3F);
    step();
    check(count == 0 && ovf_irq, "R4 R8 4-bit wrap", count, 0);

    // R6 tone period at 4 bits
    cnt_wr = 1; cnt_wdata = 0; step(); cnt_wr = 0; t0 = out_pin; errs = 0;
    for (int k = 1; k <= 64; k++) begin
      step();
      if (out_pin != (t0 ^ ((k / 16) & 1))) errs++;
    end
    check(errs == 0, "R6 tone every 16", errs, 0);

    // R12 priority and idle
    pwm_en = 1; enable = 0; rld_wr = 1; rld_wdata = 0; step();
    rld_wr = 0; enable = 1; hi = 0;
    for (int i = 0; i < 48; i++) begin step(); if (out_pin) hi++; end
    check(hi == 0, "R12 pwm overrides tone", hi, 0);
    pwm_en = 0; tog_en = 0; hi = 0;
    for (int i = 0; i < 48; i++) begin step(); if (out_pin) hi++; end
    check(hi == 0, "R12 idle low", hi, 0);

    // R2 prescaler rates and hold
    width_sel = 0; rate_sel = 3'd5; cnt_wr = 1; cnt_wdata = 0; step(); cnt_wr = 0;
    c0 = count; repeat (40) step();
    check(count - c0 == 10, "R2 rate 5", count - c0, 10);
    rate_sel = 3'd4; c0 = count; repeat (40) step();
    check(count - c0 == 5, "R2 rate 4", count - c0, 5);
    rate_sel = 3'd7; enable = 0; c0 = count; repeat (20) step();
    check(count == c0, "R2 hold", count, c0);
    enable = 1; cnt_wr = 1; cnt_wdata = 8'h77; step(); cnt_wr = 0;
    check(count == 8'h77, "R3 write beats tick", count, 8'h77);

    // R10 R11 external events
    ext_sel = 1; cnt_wr = 1; cnt_wdata = 0; step(); cnt_wr = 0;
    for (int i = 0; i < 5; i++) begin
      ext_pin = 1; repeat (4) step();
      ext_pin = 0; repeat (4) step();
    end
    check(count == 5, "R10 five edges", count, 5);
    check(!pin_irq, "R11 masked while external", pin_irq, 0);
    enable = 0; ext_sel = 0; step();
    ext_pin = 1; repeat (4) step(); ext_pin = 0; repeat (2) step();
    check(pin_irq, "R11 edge sets", pin_irq, 1);
    pin_irq_clr = 1; step(); pin_irq_clr = 0;
    check(!pin_irq, "R11 clear", pin_irq, 0);
    ext_pin = 1; repeat (4) step(); ext_pin = 0; repeat (2) step();
    check(pin_irq, "R11 edge sets again", pin_irq, 1);
    ext_sel = 1; step();
    check(!pin_irq, "R11 external select forces 0", pin_irq, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule